// File: doc/BRIEF.md
# Multi-Channel Pulse-Code Receiver with Inactivity Default

This block sits on the receive side of a set of one-way isolated digital channels. Each channel arrives as a single-bit line that carries short pulse codes instead of a level. A burst of two or more pulses inside a decode window means the far side is sending a high level, and one lone pulse means it is sending a low level. The block rebuilds each channel's level into a bistable output that changes only when a complete code has been decoded. Between codes the output holds its value, so a sender that refreshes its level from time to time keeps the output correct even when the level never changes.

Each channel has an inactivity timer. If a channel receives no pulse for a set number of cycles, the block treats the sending side as unpowered and forces that output to its default low level. A power-good input for the output side models the receiver's own supply. While that input is low, every output enable is deasserted, which stands for a high-impedance pin. When the input returns, the outputs are driven low again and follow the next received code.

Each channel runs two state machines. The decode window has the states WIN_IDLE and WIN_OPEN. WIN_IDLE moves to WIN_OPEN on a pulse while powered. WIN_OPEN moves back to WIN_IDLE when its last window cycle ends or when power drops. The output state machine has the states CH_UNPWR, CH_DFLT, CH_LOW and CH_HIGH. Every state goes to CH_UNPWR when power-good is low. CH_UNPWR goes to CH_DFLT when power returns. In the driven states, an expired timer leads to CH_DFLT, a high verdict leads to CH_HIGH and a low verdict leads to CH_LOW. Without any of these events the state holds. Reset enters CH_DFLT.

Top module: `pulse_rx_decoder`

## Requirements
- R1: After reset, with power-good high, every channel drives its output low, with data_oe equal to 1 and data_out equal to 0.
- R2: The decode window opens on the clock edge that samples a channel's first pulse and covers the next WIN_CYC edges, including the last one. If the window holds at least two pulses, data_out becomes 1 on the edge after the window closes, which is WIN_CYC+1 edges after the first pulse.
- R3: A window that holds exactly one pulse drives data_out to 0 at the same point in time, whatever the earlier level was.
- R4: Three or more pulses in one window give the same result as two pulses, a high output.
- R5: Between decoded codes, and before the inactivity limit is reached, data_out keeps its value.
- R6: A pulse that arrives on the first edge after a window has closed is not counted in that window. It opens a new window of its own.
- R7: Every pulse restarts the channel's inactivity counter. When a channel has received no pulse for WDOG_CYC edges, its data_out falls to 0 one edge later. A channel that keeps receiving codes is never forced low.
- R8: After a channel has been forced low by its timer, the next code decodes normally, and a two-pulse code drives data_out back to 1.
- R9: One edge after power-good is sampled low, every channel has data_oe equal to 0 and data_out equal to 0. Pulses that arrive while power-good is low are not decoded.
- R10: One edge after power-good is sampled high again, every channel has data_oe equal to 1 and data_out equal to 0, whatever its level was before the power loss. The next code then decodes normally.
- R11: Channels are independent. A code on one channel changes no other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_pwr_ok | input | 1 | Output-side supply good (1 = powered) |
| pulse_in | input | NCH | Per-channel pulse line, sampled each clock |
| data_out | output | NCH | Per-channel rebuilt logic level |
| data_oe | output | NCH | Per-channel output drive enable (0 = high impedance) |

## Verification
The bench places pulses on the first and last edges of the window and on the first edge after it closes. A design that counts one edge too many or too few turns a two-pulse high into a low, or merges two separate single-pulse codes into a false high. The inactivity test keeps one channel silent while it refreshes a neighbour. It samples the silent channel on the edge just before the timer limit and on the edge just after it, which exposes an off-by-one timer, a timer that is not restarted by pulses, and a timer shared between channels. The power tests send pulses while power-good is low and then restore power to a channel that was previously high. A design that decodes while unpowered, or that keeps its old level through the power loss, shows a high output where a driven low is expected.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    typedef enum logic [1:0] {
        CH_UNPWR = 2'd0,
        CH_DFLT  = 2'd1,
        CH_LOW   = 2'd2,
        CH_HIGH  = 2'd3
    } ch_state_e;

    typedef enum logic {
        WIN_IDLE = 1'b0,
        WIN_OPEN = 1'b1
    } win_state_e;

endpackage

// File: rtl/pdec_window.sv
module pdec_window
    import pdec_pkg::*;
#(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pulse,
    output logic done,
    output logic high
);

    localparam int TW = $clog2(WIN_CYC + 1);

    win_state_e      state_q, state_d;
    logic [TW-1:0]   timer_q;
    logic [1:0]      hits_q;
    logic            done_q, high_q;
    logic            last_cyc;

    assign last_cyc = (timer_q == TW'(WIN_CYC - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE: if (enable && pulse)       state_d = WIN_OPEN;
            WIN_OPEN: if (!enable || last_cyc)   state_d = WIN_IDLE;
        endcase
    end

    // window timer, pulse count and registered verdict
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            timer_q <= '0;
            hits_q  <= '0;
            done_q  <= 1'b0;
            high_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                WIN_IDLE: begin
                    timer_q <= '0;
                    hits_q  <= (enable && pulse) ? 2'd1 : 2'd0;
                end
                WIN_OPEN: begin
                    timer_q <= timer_q + 1'b1;
                    if (pulse && hits_q != 2'd2) hits_q <= hits_q + 2'd1;
                    if (enable && last_cyc) begin
                        done_q <= 1'b1;
                        high_q <= pulse || (hits_q == 2'd2);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        done = done_q;
        high = high_q;
    end

    // R2: an open window always holds the pulse that opened it
    p_open_counted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_OPEN) |-> (hits_q != 2'd0));

    // R6: one verdict per window, never two edges in a row
    p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: the timer stays inside the window length
    p_timer_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_OPEN) |-> (timer_q < TW'(WIN_CYC)));

endmodule

// File: rtl/pdec_watchdog.sv
module pdec_watchdog #(
    parameter int WDOG_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse,
    output logic expired
);

    localparam int CW = $clog2(WDOG_CYC + 1);

    logic [CW-1:0] idle_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       idle_q <= '0;
        else if (pulse)                   idle_q <= '0;
        else if (idle_q != CW'(WDOG_CYC)) idle_q <= idle_q + 1'b1;
    end

    always_comb expired = (idle_q == CW'(WDOG_CYC));

    // R7: a pulse always restarts the inactivity count
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !expired);

    // R7: the counter saturates at its limit
    p_saturate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expired && !pulse |=> expired);

endmodule

// File: rtl/pdec_channel.sv
module pdec_channel
    import pdec_pkg::*;
#(
    parameter int WIN_CYC  = 8,
    parameter int WDOG_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic out_pwr_ok,
    input  logic pulse,
    output logic data_out,
    output logic data_oe
);

    ch_state_e st_q, st_d;
    logic      done, high, expired;

    pdec_window #(.WIN_CYC(WIN_CYC)) u_win (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (out_pwr_ok),
        .pulse  (pulse),
        .done   (done),
        .high   (high)
    );

    pdec_watchdog #(.WDOG_CYC(WDOG_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (pulse),
        .expired (expired)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_DFLT;
        else        st_q <= st_d;
    end

    // next state: power loss, then inactivity, then decoded code
    always_comb begin
        st_d = st_q;
        if (!out_pwr_ok) begin
            st_d = CH_UNPWR;
        end else begin
            unique case (st_q)
                CH_UNPWR: st_d = CH_DFLT;
                CH_DFLT, CH_LOW, CH_HIGH: begin
                    if (expired)   st_d = CH_DFLT;
                    else if (done) st_d = high ? CH_HIGH : CH_LOW;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        data_oe  = (st_q != CH_UNPWR);
        data_out = (st_q == CH_HIGH);
    end

    // R2: a high verdict while driven sets the output
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && high && out_pwr_ok && !expired && data_oe |=> data_out);

    // R3: a low verdict while driven clears the output
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done && !high && out_pwr_ok && !expired && data_oe |=> !data_out && data_oe);

    // R5: no verdict and no expiry keeps the level
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done && !expired && out_pwr_ok && data_oe |=> $stable(data_out));

    // R7: an expired timer forces the default low
    p_wdog_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !data_out);

    // R9: power loss releases the output
    p_unpwr_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_pwr_ok |=> !data_oe);

    // R9: a released output never carries a high
    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe |-> !data_out);

    // R10: returning power gives a driven low first
    p_return_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe && out_pwr_ok |=> data_oe && !data_out);

endmodule

// File: rtl/pulse_rx_decoder.sv
module pulse_rx_decoder #(
    parameter int NCH      = 5,
    parameter int WIN_CYC  = 8,
    parameter int WDOG_CYC = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           out_pwr_ok,
    input  logic [NCH-1:0] pulse_in,
    output logic [NCH-1:0] data_out,
    output logic [NCH-1:0] data_oe
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pdec_channel #(
            .WIN_CYC  (WIN_CYC),
            .WDOG_CYC (WDOG_CYC)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .out_pwr_ok (out_pwr_ok),
            .pulse      (pulse_in[g]),
            .data_out   (data_out[g]),
            .data_oe    (data_oe[g])
        );
    end

    // R11: all enables move together, since they share one supply
    p_oe_common_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe == '0) || (data_oe == '1));

endmodule

// File: tb/pulse_rx_decoder_test.sv
module pulse_rx_decoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 5;
    localparam int WIN  = 8;
    localparam int WDOG = 40;

    typedef struct {
        int    due;
        int    ch;
        logic  d;
        logic  oe;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           out_pwr_ok = 1'b1;
    logic [NCH-1:0] pulse_in = '0;
    logic [NCH-1:0] data_out, data_oe;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t sb[$];

    pulse_rx_decoder #(.NCH(NCH), .WIN_CYC(WIN), .WDOG_CYC(WDOG)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .out_pwr_ok (out_pwr_ok),
        .pulse_in   (pulse_in),
        .data_out   (data_out),
        .data_oe    (data_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare every item whose cycle has come
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due <= cyc) begin
                checks++;
                if (sb[i].due < cyc) begin
                    errors++;
                    $display("FAIL %s ch%0d: check missed at cycle %0d, expected at %0d",
                             sb[i].tag, sb[i].ch, cyc, sb[i].due);
                end else if (data_out[sb[i].ch] !== sb[i].d || data_oe[sb[i].ch] !== sb[i].oe) begin
                    errors++;
                    $display("FAIL %s ch%0d cycle %0d: data=%b oe=%b, expected data=%b oe=%b",
                             sb[i].tag, sb[i].ch, cyc, data_out[sb[i].ch], data_oe[sb[i].ch],
                             sb[i].d, sb[i].oe);
                end
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int ch, input logic d, input logic oe,
                             input int due, input string tag);
        exp_t e;
        e.due = due; e.ch = ch; e.d = d; e.oe = oe; e.tag = tag;
        sb.push_back(e);
    endtask

    // drive np[c] pulses on channel c, every other edge, from the next edge on
    task automatic send(input int np[NCH]);
        for (int j = 0; j <= WIN; j++) begin
            for (int c = 0; c < NCH; c++)
                pulse_in[c] = (j % 2 == 0) && (j / 2 < np[c]);
            @(negedge clk);
        end
        pulse_in = '0;
    endtask

    // send codes, expect a verdict on every channel that got pulses
    task automatic code(input int np[NCH], input string tag);
        int n = cyc;
        int due = n + WIN + 2;
        for (int c = 0; c < NCH; c++)
            if (np[c] > 0) expect_at(c, (np[c] >= 2), 1'b1, due, tag);
        send(np);
        while (cyc <= due) @(negedge clk);
    endtask

    task automatic code_one(input int ch, input int pulses, input string tag);
        int np[NCH];
        for (int c = 0; c < NCH; c++) np[c] = (c == ch) ? pulses : 0;
        code(np, tag);
    endtask

    // two pulses on one channel, the second gap edges after the first
    task automatic pair_gap(input int ch, input int gap);
        int n = cyc;
        pulse_in[ch] = 1'b1;
        @(negedge clk);
        pulse_in[ch] = 1'b0;
        repeat (gap - 1) @(negedge clk);
        pulse_in[ch] = 1'b1;
        @(negedge clk);
        pulse_in[ch] = 1'b0;
        while (cyc <= n + 2 * WIN + 4) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, cycle=%0d expected below 20000", cyc);
        summary();
        $finish;
    end

    initial begin
        int np[NCH];
        int n, ep;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: driven low after reset
        for (int c = 0; c < NCH; c++) expect_at(c, 1'b0, 1'b1, cyc + 2, "R1");
        repeat (3) @(negedge clk);

        // R2: pair sets, R3: single clears
        code_one(0, 2, "R2");
        code_one(0, 1, "R3");

        // R4: three and five pulses mean high
        np = '{0, 3, 5, 0, 0};
        code(np, "R4");

        // R5: hold without codes
        expect_at(1, 1'b1, 1'b1, cyc + 15, "R5");
        repeat (16) @(negedge clk);

        // R11: mixed codes on some channels, ch2 untouched stays high
        expect_at(2, 1'b1, 1'b1, cyc + WIN + 2, "R11");
        np = '{2, 1, 0, 2, 0};
        code(np, "R11");

        // R2: second pulse on the last window edge still counts
        n = cyc;
        expect_at(4, 1'b1, 1'b1, n + WIN + 2, "R2");
        pair_gap(4, WIN);

        // R6: second pulse one edge late makes two separate lows
        n = cyc;
        expect_at(4, 1'b0, 1'b1, n + WIN + 2, "R6");
        expect_at(4, 1'b0, 1'b1, n + 2 * WIN + 3, "R6");
        pair_gap(4, WIN + 1);

        // R7: ch0 goes silent while ch1 is refreshed
        n = cyc;
        ep = n + 3;
        expect_at(0, 1'b1, 1'b1, ep + WDOG, "R7");
        expect_at(0, 1'b0, 1'b1, ep + WDOG + 1, "R7");
        np = '{2, 2, 0, 0, 0};
        code(np, "R7");
        for (int k = 0; k < 5; k++) code_one(1, 2, "R7");

        // R8: recovery after the inactivity default
        code_one(0, 2, "R8");

        // R9: power loss releases all outputs, pulses ignored
        n = cyc;
        out_pwr_ok = 1'b0;
        for (int c = 0; c < NCH; c++) expect_at(c, 1'b0, 1'b0, n + 1, "R9");
        expect_at(0, 1'b0, 1'b0, n + WIN + 5, "R9");
        @(negedge clk);
        np = '{2, 2, 0, 0, 0};
        send(np);
        while (cyc <= n + WIN + 5) @(negedge clk);

        // R10: power back gives driven low, then codes decode
        n = cyc;
        out_pwr_ok = 1'b1;
        for (int c = 0; c < NCH; c++) expect_at(c, 1'b0, 1'b1, n + 1, "R10");
        repeat (2) @(negedge clk);
        code_one(0, 2, "R10");

        repeat (2) @(negedge clk);
        while (sb.size() > 0) begin
            exp_t e = sb.pop_front();
            checks++;
            errors++;
            $display("FAIL %s ch%0d: check never reached, data=? expected data=%b", e.tag, e.ch, e.d);
        end
        summary();
        $finish;
    end

endmodule